// File: doc/BRIEF.md
# Memory ECC Error Logging Unit

This unit sits next to the single-error-correct, double-error-detect decoder of a memory controller and keeps a record of the errors it reports. On every read the decoder may pulse a correctable or an uncorrectable error line. With that pulse it also presents the failing bank, row and column, the position of the corrected bit, and the low 32 bits of the read data. Each error class has its own saturating event counter and its own capture slot. A slot keeps the first error that arrives after it was last cleared.

Software reaches the unit through a small word-addressed register port. Writes take effect at the clock edge. Reads are combinational from the current state. To service errors, software reads the status word and the logs. It then sets the clear bit of each class it has handled, and finally writes the control register back to zero, which resumes counting and capture. Logging only runs while the mode register selects the SECDED mode.

Top module: `ecc_err_logger`

## Requirements
- R1: After reset every counter, valid flag, captured field, the control register and the mode register read as zero, and all addresses from 9 to 15 always read zero.
- R2: Events are counted and captured only while the mode register (address 1, field [2:0]) holds 4. With any other mode value, error pulses change nothing.
- R3: Each class counter adds one on every clock cycle in which its error pulse is high and logging is allowed. It stops at 255 and never wraps.
- R4: The status word (address 2) carries the uncorrectable count in bits [7:0] and the correctable count in bits [15:8], with zero above. All zero means no error has been seen since the last clear.
- R5: The first logged error of a class sets that class's valid flag (bit 0 of its log word). The same error captures the address word {bank[30:28], row[27:12], column[11:0]} and the 32-bit data. For correctable errors it also captures the bit position into log bits [7:1]. While the flag is set, later errors leave the captured fields unchanged.
- R6: Control register (address 0) bit 1 clears the correctable class and bit 0 clears the uncorrectable class. While a clear bit is held at 1, that class's counter, flag and captured fields stay zero and its pulses are ignored. The other class is unaffected.
- R7: An error pulse in the same cycle as the write that releases a clear bit is counted and captured.
- R8: Correctable and uncorrectable pulses in the same cycle are both counted and captured, each in its own slot.
- R9: The control register reads back its bits [1:0] and the mode register reads back its bits [2:0]. Other written bits are dropped. Correctable log at address 3, address at 4, data at 5. Uncorrectable log at 6 (bit 0 only), address at 7, data at 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_evt | input | 1 | Correctable error pulse, one per erroneous read |
| ue_evt | input | 1 | Uncorrectable error pulse, one per erroneous read |
| err_bank | input | 3 | Bank of the failing access |
| err_row | input | 16 | Row of the failing access |
| err_col | input | 12 | Column of the failing access |
| err_bit | input | 7 | Position of the corrected bit |
| err_data | input | 32 | Low word of the failing read data |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |

## Verification
An error pulse present before a rising edge shows up in the status and log words from the next cycle on. A control or mode write is visible on read-back one cycle after its strobe. A clear write wipes its slot at that same edge, and a release write lets a pulse in the same cycle through. The reference model in the bench applies each cycle's inputs at the rising edge. It compares the read data for the address being driven one time unit after the falling edge, and the bench sweeps all addresses between stimulus phases, so each result is checked in the cycle it falls due.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
   localparam int unsigned REG_AW = 4;
   localparam logic [REG_AW-1:0] RA_CTRL    = 4'd0;
   localparam logic [REG_AW-1:0] RA_MODE    = 4'd1;
   localparam logic [REG_AW-1:0] RA_STAT    = 4'd2;
   localparam logic [REG_AW-1:0] RA_CE_LOG  = 4'd3;
   localparam logic [REG_AW-1:0] RA_CE_LOC  = 4'd4;
   localparam logic [REG_AW-1:0] RA_CE_DATA = 4'd5;
   localparam logic [REG_AW-1:0] RA_UE_LOG  = 4'd6;
   localparam logic [REG_AW-1:0] RA_UE_LOC  = 4'd7;
   localparam logic [REG_AW-1:0] RA_UE_DATA = 4'd8;
   localparam logic [2:0] MODE_SECDED = 3'd4;
   // class index equals the control bit that clears it
   localparam int unsigned CLS_UE = 0;
   localparam int unsigned CLS_CE = 1;
   localparam int unsigned N_CLS  = 2;
endpackage

// File: rtl/ecc_log_slot.sv
module ecc_log_slot #(
   parameter int unsigned CNT_W    = 8,
   parameter int unsigned LOC_W    = 31,
   parameter int unsigned POS_W    = 7,
   parameter int unsigned DATA_W   = 32,
   parameter bit          KEEP_POS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              evt,
   input  logic [LOC_W-1:0]  loc,
   input  logic [POS_W-1:0]  pos,
   input  logic [DATA_W-1:0] data,
   output logic [CNT_W-1:0]  cnt_q,
   output logic              valid_q,
   output logic [LOC_W-1:0]  loc_q,
   output logic [POS_W-1:0]  pos_q,
   output logic [DATA_W-1:0] data_q
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic take;
   assign take = evt && !valid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         valid_q <= 1'b0;
         loc_q   <= '0;
         data_q  <= '0;
      end else if (clr) begin
         cnt_q   <= '0;
         valid_q <= 1'b0;
         loc_q   <= '0;
         data_q  <= '0;
      end else begin
         if (evt && (cnt_q != CNT_MAX)) cnt_q <= cnt_q + 1'b1;
         if (take) begin
            valid_q <= 1'b1;
            loc_q   <= loc;
            data_q  <= data;
         end
      end
   end

   generate
      if (KEEP_POS) begin : g_pos
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    pos_q <= '0;
            else if (clr)  pos_q <= '0;
            else if (take) pos_q <= pos;
         end
      end else begin : g_nopos
         logic unused_pos;
         assign unused_pos = ^pos;
         assign pos_q = '0;
      end
   endgenerate
endmodule

// File: rtl/ecc_log_regs.sv
module ecc_log_regs
   import ecc_log_pkg::*;
#(
   parameter int unsigned CNT_W  = 8,
   parameter int unsigned LOC_W  = 31,
   parameter int unsigned POS_W  = 7,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned BUS_W  = 32
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          reg_we,
   input  logic [REG_AW-1:0]             reg_addr,
   input  logic [BUS_W-1:0]              reg_wdata,
   input  logic [N_CLS-1:0][CNT_W-1:0]   cnt_all,
   input  logic [N_CLS-1:0]              valid_all,
   input  logic [N_CLS-1:0][LOC_W-1:0]   loc_all,
   input  logic [POS_W-1:0]              ce_pos,
   input  logic [N_CLS-1:0][DATA_W-1:0]  data_all,
   output logic [N_CLS-1:0]              clr_next,
   output logic                          log_en,
   output logic [N_CLS-1:0]              ctrl_q,
   output logic [2:0]                    mode_q,
   output logic [BUS_W-1:0]              reg_rdata
);
   logic ctrl_hit, mode_hit;
   logic unused_wdata;

   assign ctrl_hit = reg_we && (reg_addr == RA_CTRL);
   assign mode_hit = reg_we && (reg_addr == RA_MODE);
   assign unused_wdata = ^reg_wdata[BUS_W-1:3];

   // a clear write acts at its own edge, so the next value drives the slots
   assign clr_next = ctrl_hit ? reg_wdata[N_CLS-1:0] : ctrl_q;
   assign log_en   = (mode_q == MODE_SECDED);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         mode_q <= '0;
      end else begin
         if (ctrl_hit) ctrl_q <= reg_wdata[N_CLS-1:0];
         if (mode_hit) mode_q <= reg_wdata[2:0];
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         RA_CTRL:    reg_rdata[N_CLS-1:0] = ctrl_q;
         RA_MODE:    reg_rdata[2:0] = mode_q;
         RA_STAT:    reg_rdata[2*CNT_W-1:0] = {cnt_all[CLS_CE], cnt_all[CLS_UE]};
         RA_CE_LOG:  reg_rdata[POS_W:0] = {ce_pos, valid_all[CLS_CE]};
         RA_CE_LOC:  reg_rdata[LOC_W-1:0] = loc_all[CLS_CE];
         RA_CE_DATA: reg_rdata[DATA_W-1:0] = data_all[CLS_CE];
         RA_UE_LOG:  reg_rdata[0] = valid_all[CLS_UE];
         RA_UE_LOC:  reg_rdata[LOC_W-1:0] = loc_all[CLS_UE];
         RA_UE_DATA: reg_rdata[DATA_W-1:0] = data_all[CLS_UE];
         default:    reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/ecc_err_logger.sv
module ecc_err_logger
   import ecc_log_pkg::*;
#(
   parameter int unsigned CNT_W  = 8,
   parameter int unsigned BANK_W = 3,
   parameter int unsigned ROW_W  = 16,
   parameter int unsigned COL_W  = 12,
   parameter int unsigned POS_W  = 7,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned BUS_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_evt,
   input  logic              ue_evt,
   input  logic [BANK_W-1:0] err_bank,
   input  logic [ROW_W-1:0]  err_row,
   input  logic [COL_W-1:0]  err_col,
   input  logic [POS_W-1:0]  err_bit,
   input  logic [DATA_W-1:0] err_data,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [BUS_W-1:0]  reg_wdata,
   output logic [BUS_W-1:0]  reg_rdata
);
   localparam int unsigned LOC_W = BANK_W + ROW_W + COL_W;

   initial begin : elab_chk
      if (LOC_W > BUS_W - 1) $fatal(1, "address word does not fit the bus");
      if (2 * CNT_W > BUS_W) $fatal(1, "counters do not fit the status word");
      if (POS_W + 1 > BUS_W) $fatal(1, "bit position does not fit the log word");
      if (DATA_W > BUS_W)    $fatal(1, "data capture wider than the bus");
      if (BUS_W < 3)         $fatal(1, "bus too narrow for the mode field");
   end

   logic [N_CLS-1:0]             evt_v, clr_next, ctrl_q;
   logic                         log_en;
   logic [2:0]                   mode_q;
   logic [LOC_W-1:0]             loc_in;
   logic [N_CLS-1:0][CNT_W-1:0]  cnt_all;
   logic [N_CLS-1:0]             valid_all;
   logic [N_CLS-1:0][LOC_W-1:0]  loc_all;
   logic [N_CLS-1:0][POS_W-1:0]  pos_all;
   logic [N_CLS-1:0][DATA_W-1:0] data_all;

   assign loc_in = {err_bank, err_row, err_col};
   assign evt_v[CLS_UE] = ue_evt;
   assign evt_v[CLS_CE] = ce_evt;

   generate
      for (genvar g = 0; g < N_CLS; g++) begin : g_cls
         ecc_log_slot #(
            .CNT_W(CNT_W), .LOC_W(LOC_W), .POS_W(POS_W), .DATA_W(DATA_W),
            .KEEP_POS(g == CLS_CE)
         ) u_slot (
            .clk(clk), .rst_n(rst_n),
            .clr(clr_next[g]), .evt(evt_v[g] && log_en),
            .loc(loc_in), .pos(err_bit), .data(err_data),
            .cnt_q(cnt_all[g]), .valid_q(valid_all[g]), .loc_q(loc_all[g]),
            .pos_q(pos_all[g]), .data_q(data_all[g])
         );
      end
   endgenerate

   logic unused_ue_pos;
   assign unused_ue_pos = ^pos_all[CLS_UE];

   ecc_log_regs #(
      .CNT_W(CNT_W), .LOC_W(LOC_W), .POS_W(POS_W), .DATA_W(DATA_W), .BUS_W(BUS_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .cnt_all(cnt_all), .valid_all(valid_all), .loc_all(loc_all),
      .ce_pos(pos_all[CLS_CE]), .data_all(data_all),
      .clr_next(clr_next), .log_en(log_en), .ctrl_q(ctrl_q), .mode_q(mode_q),
      .reg_rdata(reg_rdata)
   );
endmodule

// File: rtl/ecc_err_logger_chk.sv
module ecc_err_logger_chk
   import ecc_log_pkg::*;
#(
   parameter int unsigned CNT_W  = 8,
   parameter int unsigned LOC_W  = 31,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned BUS_W  = 32
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          ce_evt,
   input logic                          reg_we,
   input logic [REG_AW-1:0]             reg_addr,
   input logic [BUS_W-1:0]              reg_wdata,
   input logic [N_CLS-1:0]              ctrl_q,
   input logic [2:0]                    mode_q,
   input logic [N_CLS-1:0][CNT_W-1:0]   cnt_all,
   input logic [N_CLS-1:0]              valid_all,
   input logic [N_CLS-1:0][LOC_W-1:0]   loc_all,
   input logic [N_CLS-1:0][DATA_W-1:0]  data_all
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   logic ctrl_wr;
   assign ctrl_wr = reg_we && (reg_addr == RA_CTRL);

   assert_clear_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q[CLS_CE] && !ctrl_wr |=> cnt_all[CLS_CE] == '0 && !valid_all[CLS_CE]);

   assert_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_all[CLS_CE] == CNT_MAX && !ctrl_q[CLS_CE] && !ctrl_wr
      |=> cnt_all[CLS_CE] == CNT_MAX);

   assert_mode_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q != MODE_SECDED && !ctrl_q[CLS_UE] && !ctrl_wr
      |=> $stable(cnt_all[CLS_UE]) && $stable(valid_all[CLS_UE]));

   assert_first_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
      valid_all[CLS_CE] && !ctrl_q[CLS_CE] && !ctrl_wr
      |=> valid_all[CLS_CE] && $stable(loc_all[CLS_CE]) && $stable(data_all[CLS_CE]));

   assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q[CLS_CE] && ctrl_wr && !reg_wdata[CLS_CE] && ce_evt && mode_q == MODE_SECDED
      |=> cnt_all[CLS_CE] == 1 && valid_all[CLS_CE]);
endmodule

bind ecc_err_logger ecc_err_logger_chk #(
   .CNT_W(CNT_W), .LOC_W(LOC_W), .DATA_W(DATA_W), .BUS_W(BUS_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .ce_evt(ce_evt),
   .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
   .ctrl_q(ctrl_q), .mode_q(mode_q), .cnt_all(cnt_all),
   .valid_all(valid_all), .loc_all(loc_all), .data_all(data_all)
);

// File: tb/tb_ecc_err_logger.sv
module tb_ecc_err_logger;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   logic clk = 1'b0, rst_n = 1'b0;
   logic ce_evt = 0, ue_evt = 0, reg_we = 0;
   logic [2:0]  err_bank = '0;
   logic [15:0] err_row = '0;
   logic [11:0] err_col = '0;
   logic [6:0]  err_bit = '0;
   logic [31:0] err_data = '0, reg_wdata = '0, reg_rdata;
   logic [3:0]  reg_addr = '0;

   int n_tests = 0, n_fail = 0;
   // reference model state
   int m_ctrl = 0, m_mode = 0;
   int m_ce_cnt = 0, m_ue_cnt = 0, m_ce_v = 0, m_ue_v = 0, m_ce_pos = 0;
   logic [31:0] m_ce_loc = 0, m_ue_loc = 0, m_ce_data = 0, m_ue_data = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ecc_err_logger dut (
      .clk(clk), .rst_n(rst_n), .ce_evt(ce_evt), .ue_evt(ue_evt),
      .err_bank(err_bank), .err_row(err_row), .err_col(err_col),
      .err_bit(err_bit), .err_data(err_data), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
   );

   function automatic logic [31:0] exp_rd(int a);
      case (a)
         0: return 32'(m_ctrl);
         1: return 32'(m_mode);
         2: return 32'((m_ce_cnt << 8) | m_ue_cnt);
         3: return 32'((m_ce_pos << 1) | m_ce_v);
         4: return m_ce_loc;
         5: return m_ce_data;
         6: return 32'(m_ue_v);
         7: return m_ue_loc;
         8: return m_ue_data;
         default: return 32'd0;
      endcase
   endfunction

   task automatic model_edge(bit ce, bit ue, bit we, int a, logic [31:0] wd);
      int clr;
      logic [31:0] loc;
      clr = (we && a == 0) ? int'(wd[1:0]) : m_ctrl;
      loc = {1'b0, err_bank, err_row, err_col};
      if (clr[1]) begin
         m_ce_cnt = 0; m_ce_v = 0; m_ce_pos = 0; m_ce_loc = 0; m_ce_data = 0;
      end else if (ce && m_mode == 4) begin
         if (m_ce_cnt < 255) m_ce_cnt++;
         if (m_ce_v == 0) begin
            m_ce_v = 1; m_ce_pos = int'(err_bit); m_ce_loc = loc; m_ce_data = err_data;
         end
      end
      if (clr[0]) begin
         m_ue_cnt = 0; m_ue_v = 0; m_ue_loc = 0; m_ue_data = 0;
      end else if (ue && m_mode == 4) begin
         if (m_ue_cnt < 255) m_ue_cnt++;
         if (m_ue_v == 0) begin
            m_ue_v = 1; m_ue_loc = loc; m_ue_data = err_data;
         end
      end
      if (we && a == 0) m_ctrl = int'(wd[1:0]);
      if (we && a == 1) m_mode = int'(wd[2:0]);
   endtask

   // called just after a falling edge; compares the current read, then applies an edge
   task automatic step(bit ce, bit ue, bit we, int a, logic [31:0] wd, string tag);
      logic [31:0] e;
      ce_evt = ce; ue_evt = ue; reg_we = we; reg_addr = a[3:0]; reg_wdata = wd;
      #1;
      e = exp_rd(a);
      n_tests++;
      if (reg_rdata !== e) begin
         n_fail++;
         $display("FAIL %s addr %0d: actual %h expected %h", tag, a, reg_rdata, e);
      end
      @(posedge clk);
      model_edge(ce, ue, we, a, wd);
      @(negedge clk);
   endtask

   task automatic read_all(string tag);
      for (int a = 0; a < 16; a++) step(0, 0, 0, a, 32'd0, tag);
   endtask

   task automatic wr(int a, logic [31:0] d, string tag);
      step(0, 0, 1, a, d, tag);
   endtask

   task automatic set_err(int b, int r, int c, int p, logic [31:0] d);
      err_bank = b[2:0]; err_row = r[15:0]; err_col = c[11:0];
      err_bit = p[6:0]; err_data = d;
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin : watchdog
      repeat (WATCHDOG) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      read_all("R1");

      // R2: mode 0, events must be ignored
      set_err(1, 16'h0101, 12'h011, 3, 32'h1111_2222);
      for (int i = 0; i < 3; i++) step(1, 1, 0, 2, 0, "R2");
      read_all("R2");

      wr(1, 32'd4, "R9");
      step(0, 0, 0, 1, 0, "R9");

      // R5: first correctable error captured, second one dropped
      set_err(5, 16'hABCD, 12'h123, 45, 32'hDEAD_BEEF);
      step(1, 0, 0, 3, 0, "R5");
      set_err(2, 16'h1234, 12'hFFF, 7, 32'h0BAD_F00D);
      step(1, 0, 0, 4, 0, "R5");
      read_all("R3 R4 R5");

      // R8: both classes in the same cycle
      set_err(7, 16'hFFFF, 12'h800, 127, 32'hCAFE_0001);
      step(1, 1, 0, 2, 0, "R8");
      read_all("R8");

      // R3: saturation
      for (int i = 0; i < 260; i++) step(1, 0, 0, 2, 0, "R3");
      read_all("R3");

      // R6: hold correctable clear; uncorrectable keeps counting
      wr(0, 32'd2, "R6");
      for (int i = 0; i < 5; i++) step(1, 1, 0, 2, 0, "R6");
      read_all("R6");

      // R7: release with an event in the same cycle
      set_err(3, 16'h5A5A, 12'h0A5, 99, 32'h7777_8888);
      step(1, 0, 1, 0, 32'd0, "R7");
      read_all("R7");

      // R6: clear the uncorrectable class, then release
      wr(0, 32'd1, "R6");
      for (int i = 0; i < 2; i++) step(1, 1, 0, 2, 0, "R6");
      read_all("R6");
      wr(0, 32'd0, "R6");
      set_err(6, 16'h0F0F, 12'h3C3, 12, 32'h0000_ABCD);
      step(0, 1, 0, 2, 0, "R6");
      read_all("R6");

      // R2: non-SECDED mode blocks events
      wr(1, 32'd7, "R2");
      for (int i = 0; i < 3; i++) step(1, 1, 0, 2, 0, "R2");
      read_all("R2");

      // R9: upper written bits dropped
      wr(1, 32'hFFFF_FFFC, "R9");
      wr(0, 32'hFFFF_FFF0, "R9");
      step(1, 1, 0, 2, 0, "R9");
      read_all("R9");

      finish_run();
   end
endmodule